// File: doc/BRIEF.md
# ATA Cycle Timing Quantizer

This unit turns a transfer timing request, expressed as a total cycle time, an active (strobe) time and an address setup time in nanoseconds, into clock counts for the device strobe generator. The bus clock frequency arrives as an input in whole MHz. When that input is zero, a default frequency (33 MHz) applies. The unit derives the clock period by integer division, rounds each time up to whole clocks, and splits the cycle into active and recovery phases. It then clamps every field to what the strobe hardware can count and packs the result into a timing byte and a two-bit setup code.

A job begins with a one-cycle `start_i`. The unit then runs four divisions one after the other on a shared shift-and-subtract divider and reports the result with a one-cycle `done_o`. The results stay on the outputs until the next job completes. On the secondary channel both drives share one address setup field. For that channel the unit remembers the last setup count computed for each drive and reports the larger of the pair.

Top module: `ata_timing_quantizer`

## Requirements
- R1: The clock period in ns is 1000 divided by `freq_mhz_i`, using integer division. When `freq_mhz_i` is 0, the divisor is 33 (a period of 30 ns).
- R2: Each of the three times is converted to clocks by ceiling division, `(t + period - 1) / period`, with integer arithmetic.
- R3: The recovery count is the cycle count minus the active count. When the active count is equal to or greater than the cycle count, the recovery count is 0.
- R4: When the recovery count exceeds 16, the excess is moved into the active count and the recovery count becomes 16.
- R5: After the R4 adjustment, the active count is clamped to 16 and the setup count is clamped to 5. `act_cnt_o`, `rec_cnt_o` and `setup_cnt_o` carry these final counts.
- R6: `timing_o[7:4]` holds the active count modulo 16. `timing_o[3:0]` holds the recovery code: 15 for a recovery of 0 or 1, r-1 for r from 2 to 15, and 0 for 16.
- R7: `setup_code_o` maps the final setup count as follows: 0, 1 and 2 map to 1; 3 maps to 2; 4 maps to 0; 5 maps to 3.
- R8: On a secondary job (`secondary_i`=1), the unit stores the job's clamped setup count for drive `drive_i`. The reported setup count is the maximum of that value and the stored count of the other drive. Stored counts reset to 0. A primary job reports its own count and leaves the stored counts unchanged.
- R9: `start_i` is accepted only while `busy_o` is low, and a start raised during a job is ignored. `done_o` is a single-cycle pulse one cycle after the last divide step. The outputs change only on that pulse and otherwise hold.
- R10: After reset, `busy_o`, `done_o` and all result outputs are 0.
- R11: At the default 33 MHz, the three multiword DMA pairs give the following timing bytes: 120/70 ns gives 0x3F, 150/80 ns gives 0x31, and 480/215 ns gives 0x87.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Begin a job; accepted when idle |
| freq_mhz_i | input | FREQ_W | Bus clock in MHz; 0 selects the default |
| cycle_ns_i | input | NS_W | Requested total cycle time, ns |
| active_ns_i | input | NS_W | Requested active time, ns |
| setup_ns_i | input | NS_W | Requested address setup time, ns |
| secondary_i | input | 1 | Job belongs to the secondary channel |
| drive_i | input | 1 | Drive index within the channel |
| busy_o | output | 1 | Job in progress |
| done_o | output | 1 | One-cycle result strobe |
| act_cnt_o | output | 5 | Final active count |
| rec_cnt_o | output | 5 | Final recovery count |
| setup_cnt_o | output | 3 | Final (paired) setup count |
| timing_o | output | 8 | Packed active/recovery byte |
| setup_code_o | output | 2 | Encoded setup field |

## Verification
Two events can coincide in one cycle: the `done_o` strobe of one job and the `start_i` of the next job. The bench raises the next start in the same cycle in which it sees `done_o`, for every job of the frequency sweep. It then judges each result against a model of the arithmetic. This confirms that the new job is accepted and that the previous result holds until the new strobe. A start raised in the middle of a job must leave the first job's result unchanged. A run of secondary and primary jobs must show the pair maximum and show that primary jobs leave the stored counts untouched.

// File: rtl/ata_tq_pkg.sv
package ata_tq_pkg;
  typedef enum logic [2:0] {
    S_IDLE, S_PER, S_CYC, S_ACT, S_SET, S_FIN
  } tq_state_e;

  function automatic logic [1:0] setup_code(input logic [2:0] n);
    case (n)
      3'd0, 3'd1, 3'd2: setup_code = 2'd1;
      3'd3:             setup_code = 2'd2;
      3'd4:             setup_code = 2'd0;
      default:          setup_code = 2'd3;
    endcase
  endfunction
endpackage

// File: rtl/tq_divider.sv
module tq_divider #(
  parameter int W = 12
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         start_i,
  input  logic [W-1:0] dividend_i,
  input  logic [W-1:0] divisor_i,
  output logic         done_o,
  output logic [W-1:0] quot_o
);
  localparam int CW = $clog2(W + 1);
  localparam int W2 = 2 * W;

  logic [W-1:0]  rem_q, quo_q, dvs_q, dvd_q;
  logic [CW-1:0] cnt_q;
  logic          run_q;
  logic [W:0]    sh, diff;
  logic          ge;

  always_comb begin
    sh   = {rem_q, quo_q[W-1]};
    diff = sh - {1'b0, dvs_q};
    ge   = (sh >= {1'b0, dvs_q});
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rem_q  <= '0;
      quo_q  <= '0;
      dvs_q  <= '0;
      dvd_q  <= '0;
      cnt_q  <= '0;
      run_q  <= 1'b0;
      done_o <= 1'b0;
    end else begin
      done_o <= 1'b0;
      if (start_i && !run_q) begin
        rem_q <= '0;
        quo_q <= dividend_i;
        dvd_q <= dividend_i;
        dvs_q <= divisor_i;
        cnt_q <= CW'(W);
        run_q <= 1'b1;
      end else if (run_q) begin
        rem_q <= ge ? diff[W-1:0] : sh[W-1:0];
        quo_q <= {quo_q[W-2:0], ge};
        cnt_q <= cnt_q - 1'b1;
        if (cnt_q == CW'(1)) begin
          run_q  <= 1'b0;
          done_o <= 1'b1;
        end
      end
    end
  end

  assign quot_o = quo_q;

  // R2
  div_exact_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> ((W2'(quo_q) * W2'(dvs_q) <= W2'(dvd_q)) &&
                (W2'(dvd_q) - W2'(quo_q) * W2'(dvs_q) < W2'(dvs_q))));
endmodule

// File: rtl/tq_encode.sv
module tq_encode #(
  parameter int W = 12
) (
  input  logic [W-1:0] cyc_i,
  input  logic [W-1:0] act_i,
  input  logic [W-1:0] set_i,
  output logic [4:0]   act_o,
  output logic [4:0]   rec_o,
  output logic [2:0]   set_o,
  output logic [7:0]   timing_o
);
  localparam logic [W-1:0] LIM16 = W'(16);
  localparam logic [W-1:0] LIM5  = W'(5);

  logic [W-1:0] rec_raw, act_adj;
  logic [3:0]   rec_code;

  always_comb begin
    rec_raw = (cyc_i > act_i) ? (cyc_i - act_i) : '0;
    if (rec_raw > LIM16) begin
      act_adj = cyc_i - LIM16;
      rec_o   = 5'd16;
    end else begin
      act_adj = act_i;
      rec_o   = rec_raw[4:0];
    end
    act_o = (act_adj > LIM16) ? 5'd16 : act_adj[4:0];
    set_o = (set_i > LIM5) ? 3'd5 : set_i[2:0];
    // short recovery is never shortened further
    if (rec_o <= 5'd1)       rec_code = 4'd15;
    else if (rec_o == 5'd16) rec_code = 4'd0;
    else                     rec_code = 4'(rec_o - 5'd1);
    timing_o = {act_o[3:0], rec_code};
  end
endmodule

// File: rtl/tq_setup_pair.sv
module tq_setup_pair #(
  parameter int DRIVES = 2
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       wr_i,
  input  logic       sec_i,
  input  logic       drv_i,
  input  logic [2:0] own_i,
  output logic [2:0] used_o
);
  logic [2:0] slot_q [DRIVES];
  logic [2:0] pair;

  assign pair   = slot_q[~drv_i];
  assign used_o = (sec_i && pair > own_i) ? pair : own_i;

  for (genvar d = 0; d < DRIVES; d++) begin : g_slot
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) slot_q[d] <= '0;
      else if (wr_i && sec_i && drv_i == 1'(d)) slot_q[d] <= own_i;
    end
  end

  // R8
  primary_keep_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && !sec_i) |=> ($stable(slot_q[0]) && $stable(slot_q[1])));
  // R8
  pair_max_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_i |-> (used_o >= own_i && (!sec_i || used_o >= pair)));
endmodule

// File: rtl/ata_timing_quantizer.sv
module ata_timing_quantizer
  import ata_tq_pkg::*;
#(
  parameter int NS_W    = 11,
  parameter int FREQ_W  = 7,
  parameter int DEF_MHZ = 33
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [FREQ_W-1:0] freq_mhz_i,
  input  logic [NS_W-1:0]   cycle_ns_i,
  input  logic [NS_W-1:0]   active_ns_i,
  input  logic [NS_W-1:0]   setup_ns_i,
  input  logic              secondary_i,
  input  logic              drive_i,
  output logic              busy_o,
  output logic              done_o,
  output logic [4:0]        act_cnt_o,
  output logic [4:0]        rec_cnt_o,
  output logic [2:0]        setup_cnt_o,
  output logic [7:0]        timing_o,
  output logic [1:0]        setup_code_o
);
  localparam int DIV_W = NS_W + 1;

  tq_state_e         state_q;
  logic              go_q;
  logic [FREQ_W-1:0] freq_q;
  logic [NS_W-1:0]   cyc_ns_q, act_ns_q, set_ns_q;
  logic              sec_q, drv_q;
  logic [DIV_W-1:0]  per_q, cyc_cnt_q, act_cnt_q, set_cnt_q;
  logic [DIV_W-1:0]  dvd, dvs, quot;
  logic [NS_W-1:0]   t_sel;
  logic              div_done;
  logic [4:0]        enc_act, enc_rec;
  logic [2:0]        enc_set, used_set;
  logic [7:0]        enc_timing;

  always_comb begin
    case (state_q)
      S_CYC:   t_sel = cyc_ns_q;
      S_ACT:   t_sel = act_ns_q;
      default: t_sel = set_ns_q;
    endcase
    if (state_q == S_PER) begin
      dvd = DIV_W'(1000);
      dvs = (freq_q == '0) ? DIV_W'(DEF_MHZ) : DIV_W'(freq_q);
    end else begin
      dvd = DIV_W'(t_sel) + per_q - 1'b1;
      dvs = per_q;
    end
  end

  tq_divider #(.W(DIV_W)) u_div (
    .clk_i, .rst_ni,
    .start_i   (go_q),
    .dividend_i(dvd),
    .divisor_i (dvs),
    .done_o    (div_done),
    .quot_o    (quot)
  );

  tq_encode #(.W(DIV_W)) u_enc (
    .cyc_i   (cyc_cnt_q),
    .act_i   (act_cnt_q),
    .set_i   (set_cnt_q),
    .act_o   (enc_act),
    .rec_o   (enc_rec),
    .set_o   (enc_set),
    .timing_o(enc_timing)
  );

  tq_setup_pair #(.DRIVES(2)) u_pair (
    .clk_i, .rst_ni,
    .wr_i  (state_q == S_FIN),
    .sec_i (sec_q),
    .drv_i (drv_q),
    .own_i (enc_set),
    .used_o(used_set)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q      <= S_IDLE;
      go_q         <= 1'b0;
      freq_q       <= '0;
      cyc_ns_q     <= '0;
      act_ns_q     <= '0;
      set_ns_q     <= '0;
      sec_q        <= 1'b0;
      drv_q        <= 1'b0;
      per_q        <= '0;
      cyc_cnt_q    <= '0;
      act_cnt_q    <= '0;
      set_cnt_q    <= '0;
      done_o       <= 1'b0;
      act_cnt_o    <= '0;
      rec_cnt_o    <= '0;
      setup_cnt_o  <= '0;
      timing_o     <= '0;
      setup_code_o <= '0;
    end else begin
      go_q   <= 1'b0;
      done_o <= 1'b0;
      case (state_q)
        S_IDLE: if (start_i) begin
          freq_q   <= freq_mhz_i;
          cyc_ns_q <= cycle_ns_i;
          act_ns_q <= active_ns_i;
          set_ns_q <= setup_ns_i;
          sec_q    <= secondary_i;
          drv_q    <= drive_i;
          state_q  <= S_PER;
          go_q     <= 1'b1;
        end
        S_PER: if (div_done) begin
          per_q <= quot; state_q <= S_CYC; go_q <= 1'b1;
        end
        S_CYC: if (div_done) begin
          cyc_cnt_q <= quot; state_q <= S_ACT; go_q <= 1'b1;
        end
        S_ACT: if (div_done) begin
          act_cnt_q <= quot; state_q <= S_SET; go_q <= 1'b1;
        end
        S_SET: if (div_done) begin
          set_cnt_q <= quot; state_q <= S_FIN;
        end
        S_FIN: begin
          act_cnt_o    <= enc_act;
          rec_cnt_o    <= enc_rec;
          setup_cnt_o  <= used_set;
          timing_o     <= enc_timing;
          setup_code_o <= setup_code(used_set);
          done_o       <= 1'b1;
          state_q      <= S_IDLE;
        end
        default: state_q <= S_IDLE;
      endcase
    end
  end

  assign busy_o = (state_q != S_IDLE);

  // R9
  done_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  // R9
  done_after_busy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> $past(busy_o));
  // R9
  hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !done_o |-> ($stable(timing_o) && $stable(setup_code_o) && $stable(setup_cnt_o)));
  // R5
  clamp_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (act_cnt_o <= 5'd16 && rec_cnt_o <= 5'd16 && setup_cnt_o <= 3'd5));
  // R4
  rec_fold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && rec_cnt_o == 5'd16 && cyc_cnt_q <= DIV_W'(32)) |->
      (DIV_W'(act_cnt_o) == cyc_cnt_q - DIV_W'(16)));
endmodule

// File: tb/sim_ata_timing_quantizer.sv
module sim_ata_timing_quantizer;
  localparam int CLK_NS = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [6:0]  freq = '0;
  logic [10:0] cyc_ns = '0, act_ns = '0, set_ns = '0;
  logic        sec = 1'b0, drv = 1'b0;
  logic        busy, done;
  logic [4:0]  act_cnt, rec_cnt;
  logic [2:0]  set_cnt;
  logic [7:0]  timing;
  logic [1:0]  set_code;

  int n_cmp = 0;
  int n_bad = 0;
  bit finished = 0;

  always #(CLK_NS / 2) clk = ~clk;

  ata_timing_quantizer u0 (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .freq_mhz_i(freq),
    .cycle_ns_i(cyc_ns), .active_ns_i(act_ns), .setup_ns_i(set_ns),
    .secondary_i(sec), .drive_i(drv), .busy_o(busy), .done_o(done),
    .act_cnt_o(act_cnt), .rec_cnt_o(rec_cnt), .setup_cnt_o(set_cnt),
    .timing_o(timing), .setup_code_o(set_code)
  );

  task automatic chk(input string req, input int actual, input int expected);
    n_cmp++;
    if (actual !== expected) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, actual, expected);
    end
  endtask

  function automatic int rec_code(input int r);
    if (r <= 1) return 15;
    if (r == 16) return 0;
    return r - 1;
  endfunction

  function automatic int scode(input int n);
    case (n)
      0, 1, 2: return 1;
      3:       return 2;
      4:       return 0;
      default: return 3;
    endcase
  endfunction

  task automatic model(input int f, input int c, input int a, input int s,
                       output int ea, output int er, output int es);
    int p, cc, ac, sc, r;
    p  = 1000 / ((f == 0) ? 33 : f);
    cc = (c + p - 1) / p;
    ac = (a + p - 1) / p;
    sc = (s + p - 1) / p;
    r  = (cc > ac) ? cc - ac : 0;
    if (r > 16) begin ac = ac + r - 16; r = 16; end
    ea = (ac > 16) ? 16 : ac;
    er = r;
    es = (sc > 5) ? 5 : sc;
  endtask

  // caller stands at a negedge; drives immediately
  task automatic launch(input int f, input int c, input int a, input int s,
                        input bit sc, input bit dv);
    freq = 7'(f); cyc_ns = 11'(c); act_ns = 11'(a); set_ns = 11'(s);
    sec = sc; drv = dv; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic wait_done();
    int k = 0;
    while (!done && k < 400) begin
      @(negedge clk);
      k++;
    end
    if (!done) chk("R9 done timeout", 0, 1);
  endtask

  task automatic job_check(input int f, input int c, input int a, input int s);
    int ea, er, es;
    launch(f, c, a, s, 1'b0, 1'b0);
    wait_done();
    model(f, c, a, s, ea, er, es);
    chk("R3/R4 recovery count", int'(rec_cnt), er);
    chk("R5 active count", int'(act_cnt), ea);
    chk("R6 timing byte", int'(timing), ((ea % 16) << 4) | rec_code(er));
    chk("R7 setup code", int'(set_code), scode(es));
    chk("R2 setup count", int'(set_cnt), es);
  endtask

  task automatic sec_job(input int s, input bit dv, input bit sc, input int exp_cnt);
    launch(0, 600, 300, s, sc, dv);
    wait_done();
    chk("R8 paired setup count", int'(set_cnt), exp_cnt);
    chk("R8 paired setup code", int'(set_code), scode(exp_cnt));
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog expired");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    int cyc_list [10] = '{30, 70, 120, 150, 240, 383, 480, 600, 900, 1500};
    int act_list [6]  = '{15, 70, 80, 215, 290, 700};
    int ea, er, es;
    int keep;

    repeat (3) @(negedge clk);
    // R10 reset state
    chk("R10 busy", int'(busy), 0);
    chk("R10 done", int'(done), 0);
    chk("R10 timing", int'(timing), 0);
    chk("R10 setup code", int'(set_code), 0);
    chk("R10 counts", int'({act_cnt, rec_cnt, set_cnt}), 0);
    rst_n = 1'b1;
    @(negedge clk);

    // R11 multiword DMA pairs at the default frequency
    launch(0, 120, 70, 30, 1'b0, 1'b0); wait_done();
    chk("R11 mode2 byte", int'(timing), 8'h3F);
    launch(0, 150, 80, 30, 1'b0, 1'b0); wait_done();
    chk("R11 mode1 byte", int'(timing), 8'h31);
    launch(0, 480, 215, 30, 1'b0, 1'b0); wait_done();
    chk("R11 mode0 byte", int'(timing), 8'h87);

    // R1 R2: period edge values (1000/33=30, 1000/40=25, 1000/27=37)
    launch(0, 31, 30, 30, 1'b0, 1'b0); wait_done();
    chk("R1 default period", int'(act_cnt), 1);
    chk("R2 ceiling", int'(rec_cnt), 1);
    launch(27, 75, 37, 38, 1'b0, 1'b0); wait_done();
    chk("R1 period 37", int'(act_cnt), 1);
    chk("R2 ceiling 75/37", int'(rec_cnt), 2);
    chk("R2 setup 38/37", int'(set_cnt), 2);

    // sweep: every start coincides with the previous done (R9)
    job_check(0, 900, 100, 100);
    for (int f = 25; f <= 50; f++)
      for (int i = 0; i < 10; i++)
        for (int j = 0; j < 6; j++)
          job_check(f, cyc_list[i], act_list[j], (cyc_list[i] * 7 + act_list[j]) % 260);

    // R9 start ignored while busy
    launch(30, 900, 100, 40, 1'b0, 1'b0);
    repeat (6) @(negedge clk);
    launch(45, 60, 30, 200, 1'b0, 1'b0);
    wait_done();
    model(30, 900, 100, 40, ea, er, es);
    chk("R9 ignored start act", int'(act_cnt), ea);
    chk("R9 ignored start rec", int'(rec_cnt), er);
    chk("R9 ignored start setup", int'(set_cnt), es);
    @(negedge clk);
    chk("R9 idle after job", int'(busy), 0);

    // R9 outputs hold without start
    keep = int'(timing);
    freq = 7'd50; cyc_ns = 11'd40; act_ns = 11'd20; set_ns = 11'd5;
    repeat (30) @(negedge clk);
    chk("R9 hold timing", int'(timing), keep);
    chk("R9 no done", int'(done), 0);

    // R8 secondary pairing at 30 ns period: 10->1, 60->2, 130->5
    sec_job(10, 1'b0, 1'b1, 1);   // pair slot from reset is 0
    sec_job(60, 1'b1, 1'b1, 2);
    sec_job(130, 1'b0, 1'b1, 5);
    sec_job(10, 1'b1, 1'b0, 1);   // primary: own count only
    sec_job(10, 1'b0, 1'b1, 2);   // slot1 still 2
    sec_job(10, 1'b1, 1'b1, 1);   // slot0 now 1
    sec_job(200, 1'b0, 1'b0, 5);  // R5 setup clamp 7->5
    sec_job(100, 1'b0, 1'b0, 4);  // R7 count 4 -> code 0

    finished = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule